// File: doc/BRIEF.md
# Three-Level PWM Phase-Reversal Carrier Transmitter

This block turns a serial bit stream into a binary phase-shift keyed carrier carried on two digital pulse lines. One line carries the positive half of a three-level waveform and the other carries the negative half. An external analog stage subtracts the second line from the first and low-pass filters the result into a sine. Each carrier period is built from twelve ticks of a strobe that runs at twelve times the carrier frequency. The period holds one positive pulse and one negative pulse, each one third of a period wide, with idle gaps of one sixth of a period in between.

Bits arrive through a valid/ready handshake. The block takes a bit only on a bit boundary. A boundary is either the first tick while the block is idle, or the last tick of the bit being sent. Each bit occupies exactly twenty-four carrier periods. A 0 is sent at phase 0 and a 1 at phase 180 degrees, so the polarity can change only from one bit to the next. A one-tick strobe marks the last tick of every bit. When no bit is waiting at a boundary, both pulse lines fall low and the block goes idle.

Top module: `bpskPwmTx`

## Requirements
- R1: While rstN is low and after its release, before any bit is accepted, posPulse, negPulse and bitEnd are low.
- R2: bitReady is high only in a cycle where tick is high and the block is either idle or on the last tick of a bit. A bit is taken when bitValid and bitReady are both high, and at no other time.
- R3: posPulse and negPulse are never high in the same cycle.
- R4: For a bit with value 0, the tick index counts 0 to 11 within each carrier period. Index 0 is the period from the accepting tick up to the next tick. At indices 2 to 5 posPulse is high. At indices 8 to 11 negPulse is high. At indices 0, 1, 6 and 7 both lines are low.
- R5: For a bit with value 1, the pattern of R4 applies with posPulse and negPulse swapped.
- R6: Each bit lasts exactly 24 carrier periods (288 ticks). bitEnd is high for one cycle, in the cycle carrying the 288th tick of the bit, and only when bitReady is also high.
- R7: If no bit is valid at a boundary, both pulse lines stay low from the next cycle until a bit is accepted.
- R8: A bit accepted at the last tick of the previous bit begins at tick index 0 with no gap, using its own polarity.
- R9: The pulse lines and the tick position change only on clock edges where tick is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at twelve times the carrier frequency |
| bitValid | input | 1 | A data bit is offered |
| bitData | input | 1 | Offered bit value; 1 selects phase reversal |
| bitReady | output | 1 | The offered bit is taken in this cycle if valid |
| posPulse | output | 1 | Positive pulse line of the three-level waveform |
| negPulse | output | 1 | Negative pulse line of the three-level waveform |
| bitEnd | output | 1 | High during the last tick of each bit |

## Verification
A wrong tick or period counter shows at once as a shifted pulse edge on posPulse or negPulse, within one carrier period. It also moves bitEnd and bitReady off the 288-tick grid by the end of the bit. A wrong stored phase shows as swapped pulse lines from the first pulse of the bit, at tick index 2. A wrong idle/active state shows either as pulses with nothing accepted or as a bitReady that stays high in the middle of a bit. The bench compares every cycle against a model built from the requirements. It uses random tick spacing and random gaps between bits, so each of these faults is caught within one tick of when it first appears.

// File: rtl/bpskTxPkg.sv
package bpskTxPkg;
  // Control-to-datapath strobes for one clock cycle.
  typedef struct packed {
    logic load;     // capture a new bit and restart the position
    logic clear;    // return the position to zero without a bit
    logic advance;  // step the tick position by one
    logic drive;    // pulse lines enabled
  } txStrobes_t;
endpackage

// File: rtl/bpskTxCtl.sv
module bpskTxCtl
  import bpskTxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       bitValid,
  input  logic       atLast,
  output logic       bitReady,
  output logic       bitEnd,
  output txStrobes_t strobes
);
  logic active;
  logic atBoundary;
  logic take;

  assign atBoundary = !active || atLast;
  assign bitReady   = tick && atBoundary;
  assign bitEnd     = tick && active && atLast;
  assign take       = bitReady && bitValid;

  always_comb begin
    strobes.load    = take;
    strobes.clear   = bitReady && !bitValid;
    strobes.advance = tick && !bitReady;
    strobes.drive   = active;
  end

  always_ff @(posedge clk) begin
    if (!rstN) active <= 1'b0;
    else if (bitReady) active <= bitValid;
  end
endmodule

// File: rtl/bpskTxDatapath.sv
module bpskTxDatapath
  import bpskTxPkg::*;
#(
  parameter int TICKS_PER_CYCLE = 12,
  parameter int CYCLES_PER_BIT  = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  txStrobes_t strobes,
  input  logic       bitData,
  output logic       atLast,
  output logic       posPulse,
  output logic       negPulse
);
  localparam int TW     = $clog2(TICKS_PER_CYCLE);
  localparam int CW     = $clog2(CYCLES_PER_BIT);
  localparam int THIRD  = TICKS_PER_CYCLE / 3;
  localparam int LEAD   = THIRD / 2;
  localparam int A_LO   = LEAD;
  localparam int A_HI   = LEAD + THIRD - 1;
  localparam int B_LO   = TICKS_PER_CYCLE / 2 + LEAD;
  localparam int B_HI   = B_LO + THIRD - 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_CYCLE - 1);
  localparam logic [CW-1:0] CYC_LAST  = CW'(CYCLES_PER_BIT - 1);

  logic [TW-1:0] tickIdx;
  logic [CW-1:0] cycIdx;
  logic          phase;
  logic          firstHalf;
  logic          secondHalf;

  assign atLast = (tickIdx == TICK_LAST) && (cycIdx == CYC_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickIdx <= '0;
      cycIdx  <= '0;
      phase   <= 1'b0;
    end else if (strobes.load) begin
      tickIdx <= '0;
      cycIdx  <= '0;
      phase   <= bitData;
    end else if (strobes.clear) begin
      tickIdx <= '0;
      cycIdx  <= '0;
    end else if (strobes.advance) begin
      if (tickIdx == TICK_LAST) begin
        tickIdx <= '0;
        cycIdx  <= cycIdx + CW'(1);
      end else begin
        tickIdx <= tickIdx + TW'(1);
      end
    end
  end

  assign firstHalf  = (tickIdx >= TW'(A_LO)) && (tickIdx <= TW'(A_HI));
  assign secondHalf = (tickIdx >= TW'(B_LO)) && (tickIdx <= TW'(B_HI));

  assign posPulse = strobes.drive && (phase ? secondHalf : firstHalf);
  assign negPulse = strobes.drive && (phase ? firstHalf : secondHalf);
endmodule

// File: rtl/bpskPwmTx.sv
module bpskPwmTx
  import bpskTxPkg::*;
#(
  parameter int TICKS_PER_CYCLE = 12,
  parameter int CYCLES_PER_BIT  = 24
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick,
  input  logic bitValid,
  input  logic bitData,
  output logic bitReady,
  output logic posPulse,
  output logic negPulse,
  output logic bitEnd
);
  txStrobes_t strobes;
  logic       atLast;

  bpskTxCtl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .bitValid (bitValid),
    .atLast   (atLast),
    .bitReady (bitReady),
    .bitEnd   (bitEnd),
    .strobes  (strobes)
  );

  bpskTxDatapath #(
    .TICKS_PER_CYCLE (TICKS_PER_CYCLE),
    .CYCLES_PER_BIT  (CYCLES_PER_BIT)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .bitData  (bitData),
    .atLast   (atLast),
    .posPulse (posPulse),
    .negPulse (negPulse)
  );
endmodule

// File: rtl/bpskPwmTxChk.sv
module bpskPwmTxChk (
  input logic clk,
  input logic rstN,
  input logic tick,
  input logic bitValid,
  input logic bitData,
  input logic bitReady,
  input logic posPulse,
  input logic negPulse,
  input logic bitEnd
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
    !(posPulse && negPulse)); // R3

  AST_READY_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    bitReady |-> tick); // R2

  AST_END_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    bitEnd |-> bitReady); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (bitReady && !bitEnd) |-> (!posPulse && !negPulse)); // R7

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(posPulse) && $stable(negPulse))); // R9

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!posPulse && !negPulse)); // R1
endmodule

bind bpskPwmTx bpskPwmTxChk uChk (.*);

// File: tb/sim_bpskPwmTx.sv
`timescale 1ns/1ps
module sim_bpskPwmTx;
  logic clk = 1'b0;
  logic rstN, tick, bitValid, bitData;
  logic bitReady, posPulse, negPulse, bitEnd;

  localparam int NBITS = 40;

  always #5 clk = ~clk;

  bpskPwmTx u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .bitValid(bitValid), .bitData(bitData),
    .bitReady(bitReady), .posPulse(posPulse), .negPulse(negPulse), .bitEnd(bitEnd)
  );

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit inFirst(input int t);
    return (t >= 2) && (t <= 5);
  endfunction
  function automatic bit inSecond(input int t);
    return (t >= 8) && (t <= 11);
  endfunction

  bit mAct, mPh, mB2B;
  int mT, mC;
  bit bits [NBITS];

  initial begin
    int sentIdx, gap, tickWait;
    bit accepted, prevTick, prevPos, prevNeg;
    bit expReady, expEnd, expPos, expNeg, isLast;
    string pr;
    void'($urandom(4242));
    bits[0] = 0; bits[1] = 1; bits[2] = 1; bits[3] = 0;
    for (int i = 4; i < NBITS; i++) bits[i] = 1'($urandom_range(0, 1));

    rstN = 0; tick = 0; bitValid = 1; bitData = 1;
    repeat (3) @(negedge clk);
    tick = 1;
    #1;
    chk(!posPulse && !negPulse && !bitEnd, "R1", "outputs in reset",
        {posPulse, negPulse, bitEnd}, 0);
    @(negedge clk);
    rstN = 1; tick = 0; bitValid = 0;
    #1;
    chk(!posPulse && !negPulse && !bitEnd, "R1", "outputs after reset",
        {posPulse, negPulse, bitEnd}, 0);

    mAct = 0; mPh = 0; mT = 0; mC = 0; mB2B = 0;
    sentIdx = 0; gap = 0; tickWait = 5; accepted = 0;
    prevTick = 0; prevPos = 0; prevNeg = 0;

    for (int cyc = 0; cyc < 150000; cyc++) begin
      if (sentIdx >= NBITS && !mAct && cyc > 20) break;
      @(negedge clk);
      if (accepted) begin
        bitValid = 0;
        gap = ($urandom_range(0, 7) == 0) ? $urandom_range(50, 400) : 0;
        accepted = 0;
      end
      if (tickWait == 0) begin
        tick = 1; tickWait = $urandom_range(0, 3);
      end else begin
        tick = 0; tickWait--;
      end
      if (!bitValid && sentIdx < NBITS) begin
        if (gap == 0) begin
          bitValid = 1; bitData = bits[sentIdx];
        end else gap--;
      end
      #1;
      isLast   = mAct && (mT == 11) && (mC == 23);
      expReady = tick && (!mAct || isLast);
      expEnd   = tick && isLast;
      expPos   = mAct && (mPh ? inSecond(mT) : inFirst(mT));
      expNeg   = mAct && (mPh ? inFirst(mT) : inSecond(mT));
      pr = !mAct ? "R7" : (mB2B && mC == 0) ? "R8" : (mPh ? "R5" : "R4");
      chk(posPulse == expPos, pr, "posPulse", posPulse, expPos);
      chk(negPulse == expNeg, pr, "negPulse", negPulse, expNeg);
      chk(!(posPulse && negPulse), "R3", "both lines high", 1, 0);
      chk(bitReady == expReady, "R2", "bitReady", bitReady, expReady);
      chk(bitEnd == expEnd, "R6", "bitEnd", bitEnd, expEnd);
      if (!prevTick)
        chk(posPulse == prevPos && negPulse == prevNeg, "R9", "change without tick",
            {posPulse, negPulse}, {prevPos, prevNeg});
      prevTick = tick; prevPos = posPulse; prevNeg = negPulse;
      if (tick) begin
        if (expReady) begin
          if (bitValid) begin
            mB2B = mAct; mAct = 1; mPh = bitData; mT = 0; mC = 0;
            accepted = 1; sentIdx++;
          end else begin
            mAct = 0; mT = 0; mC = 0; mB2B = 0;
          end
        end else if (mT == 11) begin
          mT = 0; mC++;
        end else mT++;
      end
    end
    chk(sentIdx == NBITS, "R2", "bits accepted", sentIdx, NBITS);
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule